// File: doc/BRIEF.md
# Register ALU with condition codes

This block is the execute stage of a small 16-bit load/store processor. It takes one instruction per cycle while its valid strobe is high. It decodes three register-arithmetic operations: addition, bitwise AND and complement. It reads their operands from an eight-entry register file, writes the result back and records the sign of that result in three sticky condition flags: negative, zero and positive. The same stage evaluates conditional branches against those flags and keeps the program counter.

For addition and AND, a mode bit picks the second operand. It is either a second register or a sign-extended 5-bit immediate. A branch carries a three-bit mask with one bit for each of n, z and p. The branch is taken only when a flag that the mask selects is set. The taken target is the incremented program counter plus a sign-extended 9-bit offset. A debug read port exposes any register, so the surrounding pipeline or a bench can observe the register file.

Top module: `exu_core`

## Requirements
- R1: When `rst_n` is low at a clock edge, the edge clears every register to 0, sets the flags to `flags_o`=3'b010 (only Z) and loads `pc_o` with the parameter `START_PC`, which defaults to 16'h3050. It also drives `br_taken_o` to 0.
- R2: Opcode 4'b0001 in bits 15:12 with bit 5 = 0 writes R[bits 8:6] + R[bits 2:0] into R[bits 11:9]. Bits 4:3 have no effect on the result.
- R3: When bit 5 = 1 in an addition or AND, the second operand is bits 4:0 sign-extended to 16 bits, covering -16 to +15.
- R4: Opcode 4'b0101 writes the bitwise AND of the first source and the second operand into R[bits 11:9]. The second operand follows the same mode-bit rule as addition.
- R5: Opcode 4'b1001 with bits 5:0 = 6'b111111 writes the complement of R[bits 8:6] into R[bits 11:9]. With any other value in bits 5:0 it changes neither registers nor flags.
- R6: Every register write sets exactly one flag in `flags_o` = {N,Z,P} (bit 2 = N, bit 1 = Z, bit 0 = P). N is set when bit 15 of the result is 1, Z when the result is zero, and P otherwise.
- R7: Opcode 4'b0000 is a branch with mask bits 11:9 = {n,z,p}. It is taken when (mask & flags_o) is nonzero. Mask 000 never branches and mask 111 always branches.
- R8: A branch changes neither the flags nor any register.
- R9: Each accepted instruction advances `pc_o` to `pc_o`+1, or to `pc_o`+1+sext(bits 8:0) for a taken branch. From the same edge, `br_taken_o` is high for exactly the cycle after a taken branch.
- R10: While `instr_vld_i` is low, the pc, the flags and the registers hold and `br_taken_o` is 0.
- R11: Any opcode other than 0000, 0001, 0101 and 1001 only advances `pc_o` by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| instr_vld_i | input | 1 | Instruction valid strobe |
| dbg_sel_i | input | 3 | Register index for the debug read port |
| dbg_data_o | output | 16 | Contents of the selected register |
| pc_o | output | 16 | Address of the next instruction |
| br_taken_o | output | 1 | The previous accepted instruction was a taken branch |
| flags_o | output | 3 | Condition flags {N,Z,P} |

## Verification
A wrong flag state stays hidden until the next branch reads it. At that point it shows up as a wrong `br_taken_o` and a wrong `pc_o` one cycle after the branch is accepted. A wrong register value shows on `dbg_data_o` in the same cycle it is selected. It also carries into every later flag update that uses the register as a source, so the bench reads the destination back after every write. Both boundary immediates, all three flag outcomes, the never and always masks, and negative offsets are each driven, so a sign-extension or mask-bit-order slip changes the pc within one instruction.

// File: rtl/exu_pkg.sv
// Shared constants and types for the execute stage.
// Assumes a fixed 16-bit instruction word and eight general registers.
package exu_pkg;
    localparam int XLEN     = 16;
    localparam int NREG     = 8;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int IMM_W    = 5;
    localparam int BOFF_W   = 9;

    localparam logic [3:0] OP_BR  = 4'b0000;
    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_NOT = 4'b1001;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    // Sign class of a result written to the register file.
    function automatic cc_t cc_from(input logic [XLEN-1:0] v);
        cc_t c;
        c.n = v[XLEN-1];
        c.z = (v == '0);
        c.p = !v[XLEN-1] && (v != '0);
        return c;
    endfunction
endpackage

// File: rtl/exu_regfile.sv
// Register file with two operand read ports, one debug read port and one
// write port. Writes land on the clock edge; reads are combinational.
// Assumes a synchronous active-low reset that clears every entry.
module exu_regfile
    import exu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] wa_i,
    input  logic [XLEN-1:0]   wd_i,
    input  logic [RIDX_W-1:0] ra1_i,
    input  logic [RIDX_W-1:0] ra2_i,
    input  logic [RIDX_W-1:0] ra3_i,
    output logic [XLEN-1:0]   rd1_o,
    output logic [XLEN-1:0]   rd2_o,
    output logic [XLEN-1:0]   rd3_o
);
    logic [XLEN-1:0] mem_q [NREG];

    // One storage slot per register, each with its own write decode.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (we_i && (wa_i == RIDX_W'(g)))
                mem_q[g] <= wd_i;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd1_o = mem_q[ra1_i];
        rd2_o = mem_q[ra2_i];
        rd3_o = mem_q[ra3_i];
    end
endmodule

// File: rtl/exu_alu.sv
// Decodes the register-arithmetic instructions and computes their result.
// Picks the second operand by the mode bit (register or 5-bit immediate).
// Assumes the caller qualifies wr_o with the instruction valid strobe.
module exu_alu
    import exu_pkg::*;
(
    input  logic [15:0]       instr_i,
    input  logic [XLEN-1:0]   src1_i,
    input  logic [XLEN-1:0]   src2_i,
    output logic [RIDX_W-1:0] rs1_o,
    output logic [RIDX_W-1:0] rs2_o,
    output logic [RIDX_W-1:0] rd_o,
    output logic              wr_o,
    output logic [XLEN-1:0]   res_o
);
    logic [3:0]      opc;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;

    assign opc   = instr_i[15:12];
    assign rd_o  = instr_i[11:9];
    assign rs1_o = instr_i[8:6];
    assign rs2_o = instr_i[2:0];

    // Second operand selection by the mode bit.
    always_comb begin
        imm_ext = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
        opnd_b  = instr_i[5] ? imm_ext : src2_i;
    end

    // Operation decode and result.
    always_comb begin
        wr_o  = 1'b0;
        res_o = '0;
        unique case (opc)
            OP_ADD: begin wr_o = 1'b1; res_o = src1_i + opnd_b; end
            OP_AND: begin wr_o = 1'b1; res_o = src1_i & opnd_b; end
            OP_NOT: begin wr_o = (instr_i[5:0] == 6'h3F); res_o = ~src1_i; end
            default: ;
        endcase
    end
endmodule

// File: rtl/exu_branch.sv
// Evaluates a conditional branch against the flags and forms the next PC.
// The PC is incremented first; a taken branch adds the 9-bit offset to it.
module exu_branch
    import exu_pkg::*;
(
    input  logic [15:0]     instr_i,
    input  cc_t             cc_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            take_o,
    output logic [XLEN-1:0] pc_next_o
);
    logic [2:0]      mask;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] off_ext;

    // Condition test: any selected flag that is set.
    always_comb begin
        mask   = instr_i[11:9];
        take_o = (instr_i[15:12] == OP_BR) && ((mask & {cc_i.n, cc_i.z, cc_i.p}) != 3'b000);
    end

    // Sequential and target addresses.
    always_comb begin
        pc_inc    = pc_i + XLEN'(1);
        off_ext   = {{(XLEN-BOFF_W){instr_i[BOFF_W-1]}}, instr_i[BOFF_W-1:0]};
        pc_next_o = take_o ? (pc_inc + off_ext) : pc_inc;
    end
endmodule

// File: rtl/exu_core.sv
// Execute stage top: register file, ALU, branch unit, flags and PC.
// One instruction is consumed on each edge where instr_vld_i is high.
// Assumes a synchronous active-low reset held for at least one edge.
module exu_core
    import exu_pkg::*;
#(
    parameter logic [15:0] START_PC = 16'h3050
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] instr_i,
    input  logic        instr_vld_i,
    input  logic [2:0]  dbg_sel_i,
    output logic [15:0] dbg_data_o,
    output logic [15:0] pc_o,
    output logic        br_taken_o,
    output logic [2:0]  flags_o
);
    logic [RIDX_W-1:0] rs1, rs2, rd;
    logic [XLEN-1:0]   src1, src2, res, pc_nxt;
    logic              alu_wr, take;
    cc_t               cc_q;
    logic [XLEN-1:0]   pc_q;
    logic              taken_q;

    exu_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_i(instr_vld_i && alu_wr), .wa_i(rd), .wd_i(res),
        .ra1_i(rs1), .ra2_i(rs2), .ra3_i(dbg_sel_i),
        .rd1_o(src1), .rd2_o(src2), .rd3_o(dbg_data_o)
    );

    exu_alu u_alu (
        .instr_i(instr_i), .src1_i(src1), .src2_i(src2),
        .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .wr_o(alu_wr), .res_o(res)
    );

    exu_branch u_br (
        .instr_i(instr_i), .cc_i(cc_q), .pc_i(pc_q),
        .take_o(take), .pc_next_o(pc_nxt)
    );

    // Flags, program counter and branch indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q    <= CC_RESET;
            pc_q    <= START_PC;
            taken_q <= 1'b0;
        end else begin
            taken_q <= instr_vld_i && take;
            if (instr_vld_i) begin
                pc_q <= pc_nxt;
                if (alu_wr)
                    cc_q <= cc_from(res);
            end
        end
    end

    assign pc_o       = pc_q;
    assign br_taken_o = taken_q;
    assign flags_o    = {cc_q.n, cc_q.z, cc_q.p};
endmodule

// File: rtl/exu_core_chk.sv
// Port-level properties of the execute stage, attached by bind.
module exu_core_chk #(
    parameter logic [15:0] START_PC = 16'h3050
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] instr_i,
    input logic        instr_vld_i,
    input logic [15:0] pc_o,
    input logic        br_taken_o,
    input logic [2:0]  flags_o
);
    logic [3:0] opc;
    logic       known_op;
    assign opc      = instr_i[15:12];
    assign known_op = (opc == 4'b0000) || (opc == 4'b0001) || (opc == 4'b0101) || (opc == 4'b1001);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags_o == 3'b010 && pc_o == START_PC && !br_taken_o));

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_o) == 1);

    assert_never_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && opc == 4'b0000 && instr_i[11:9] == 3'b000) |=> !br_taken_o);

    assert_branch_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && opc == 4'b0000) |=> $stable(flags_o));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld_i |=> ($stable(flags_o) && $stable(pc_o) && !br_taken_o));

    assert_other_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && !known_op) |=> ($stable(flags_o) && !br_taken_o && pc_o == $past(pc_o) + 16'd1));
endmodule

bind exu_core exu_core_chk #(.START_PC(START_PC)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_vld_i(instr_vld_i),
    .pc_o(pc_o), .br_taken_o(br_taken_o), .flags_o(flags_o)
);

// File: tb/sim_exu_core.sv
// Scoreboard bench: the driver models each instruction from the requirements
// and queues the expected state; the monitor compares after each edge.
module sim_exu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = '0;
    logic        instr_vld_i = 1'b0;
    logic [2:0]  dbg_sel_i = '0;
    logic [15:0] dbg_data_o, pc_o;
    logic        br_taken_o;
    logic [2:0]  flags_o;

    typedef struct {
        string       tag;
        logic [2:0]  fl;
        logic [15:0] pc;
        logic        tk;
        int          ridx;
        logic [15:0] rval;
    } exp_t;

    exp_t        sbq[$];
    int          total = 0;
    int          bad = 0;
    bit          issued = 1'b0;
    bit          done = 1'b0;
    logic [15:0] mreg [8];
    logic [2:0]  mfl;
    logic [15:0] mpc;

    exu_core #(.START_PC(16'h3050)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_vld_i(instr_vld_i),
        .dbg_sel_i(dbg_sel_i), .dbg_data_o(dbg_data_o), .pc_o(pc_o),
        .br_taken_o(br_taken_o), .flags_o(flags_o)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc_ri(logic [3:0] op, int rd, int rs, int imm);
        logic [4:0] i5 = 5'(imm);
        return {op, 3'(rd), 3'(rs), 1'b1, i5};
    endfunction
    function automatic logic [15:0] enc_rr(logic [3:0] op, int rd, int rs1, int rs2, logic [1:0] junk);
        return {op, 3'(rd), 3'(rs1), 1'b0, junk, 3'(rs2)};
    endfunction
    function automatic logic [15:0] enc_br(logic [2:0] mask, int off);
        logic [8:0] o9 = 9'(off);
        return {4'b0000, mask, o9};
    endfunction

    // Reference model of one instruction, taken from the requirements.
    task automatic model(input logic [15:0] ins, output logic tk);
        logic [15:0] a, b, res;
        logic        wr;
        a   = mreg[ins[8:6]];
        b   = ins[5] ? {{11{ins[4]}}, ins[4:0]} : mreg[ins[2:0]];
        wr  = 1'b0;
        res = '0;
        tk  = 1'b0;
        case (ins[15:12])
            4'b0001: begin res = a + b; wr = 1'b1; end
            4'b0101: begin res = a & b; wr = 1'b1; end
            4'b1001: if (ins[5:0] == 6'h3F) begin res = ~a; wr = 1'b1; end
            4'b0000: tk = |(ins[11:9] & mfl);
            default: ;
        endcase
        mpc = mpc + 16'd1;
        if (tk) mpc = mpc + {{7{ins[8]}}, ins[8:0]};
        if (wr) begin
            mreg[ins[11:9]] = res;
            mfl = res[15] ? 3'b100 : (res == 16'h0 ? 3'b010 : 3'b001);
        end
    endtask

    // Driver: issue one instruction and queue its expected outcome.
    task automatic run(string tag, logic [15:0] ins, int ridx);
        exp_t e;
        logic tk;
        model(ins, tk);
        e = '{tag: tag, fl: mfl, pc: mpc, tk: tk, ridx: ridx, rval: mreg[ridx]};
        sbq.push_back(e);
        @(negedge clk);
        instr_i = ins; instr_vld_i = 1'b1; issued = 1'b1;
    endtask

    // Driver: one idle cycle with garbage on the instruction bus.
    task automatic idle(string tag, int ridx);
        exp_t e;
        e = '{tag: tag, fl: mfl, pc: mpc, tk: 1'b0, ridx: ridx, rval: mreg[ridx]};
        sbq.push_back(e);
        @(negedge clk);
        instr_i = enc_ri(4'b0001, ridx, ridx, 7); instr_vld_i = 1'b0; issued = 1'b1;
    endtask

    // Monitor: after each issued edge, pop and compare at the ports.
    initial begin
        forever begin
            @(posedge clk);
            if (issued && sbq.size() > 0) begin
                exp_t e;
                @(negedge clk);
                #1;
                e = sbq.pop_front();
                chk({e.tag, " pc"}, pc_o, e.pc);
                chk({e.tag, " flags"}, {13'h0, flags_o}, {13'h0, e.fl});
                chk({e.tag, " taken"}, {15'h0, br_taken_o}, {15'h0, e.tk});
                dbg_sel_i = 3'(e.ridx);
                #1;
                chk({e.tag, " reg"}, dbg_data_o, e.rval);
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        mfl = 3'b010;
        mpc = 16'h3050;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 pc", pc_o, 16'h3050);
        chk("R1 flags", {13'h0, flags_o}, 16'h0002);
        chk("R1 taken", {15'h0, br_taken_o}, 16'h0);
        for (int i = 0; i < 8; i++) begin
            dbg_sel_i = 3'(i);
            #1;
            chk("R1 reg", dbg_data_o, 16'h0);
        end

        run("R3 addi +6", enc_ri(4'b0001, 1, 0, 6), 1);
        run("R3 addi -4", enc_ri(4'b0001, 2, 0, -4), 2);
        run("R2 add reg junk", enc_rr(4'b0001, 3, 1, 2, 2'b11), 3);
        run("R4 and reg", enc_rr(4'b0101, 4, 2, 1, 2'b00), 4);
        run("R4 andi zero R6", enc_ri(4'b0101, 5, 1, 0), 5);
        run("R5 not", {4'b1001, 3'd6, 3'd2, 6'h3F}, 6);
        run("R5 not malformed", {4'b1001, 3'd7, 3'd1, 6'h00}, 7);
        run("R3 addi max", enc_ri(4'b0001, 0, 0, 15), 0);
        run("R3 addi min R6", enc_ri(4'b0001, 0, 0, -16), 0);
        run("R7 br n fwd", enc_br(3'b100, 5), 0);
        run("R8 br zp not", enc_br(3'b011, 2), 0);
        run("R7 br never", enc_br(3'b000, 3), 0);
        run("R9 br always back", enc_br(3'b111, -3), 0);
        run("R6 add to zero", enc_ri(4'b0001, 0, 0, 1), 0);
        run("R7 br z", enc_br(3'b010, -100), 0);
        idle("R10 idle", 0);
        run("R11 other op", 16'h2E3F, 7);
        run("R2 add wrap", enc_rr(4'b0001, 7, 6, 2, 2'b01), 7);
        run("R7 br p", enc_br(3'b001, 255), 7);
        run("R4 andi neg", enc_ri(4'b0101, 3, 2, -2), 3);
        idle("R10 idle end", 3);
        @(negedge clk);
        issued = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule